// File: doc/BRIEF.md
# SPI Serial Clock and Phase Generator

This block derives the serial clock of an SPI host from the system clock. An 8-bit divider sets the clock ratio. A 3-bit signalling field sets the clock polarity and two phase controls that are independent of each other. One phase control decides on which edge outgoing data changes. The other decides on which edge incoming data is sampled. Next to the SCK level, the block gives the shifter two single-cycle strobes, one for driving and one for sampling. Each strobe is high in the same cycle in which SCK makes the matching edge.

The transfer engine holds `run` high for as long as it wants clocks. The generator counts each clock it completes. When `run` falls, the generator finishes the clock in progress and then parks SCK at its idle level. Dropping `en` stops everything at once. The divider and the signalling field are sampled only while the block is idle. Because of this, the transfer engine may change them at any time without breaking a clock that is already in progress. Setting the two phase bits to opposite values moves sampling onto the drive edge, which is the setting meant for the fastest divider.

There is no data stream here: every pin is a plain control or status signal.

Top module: `spi_sck_gen`

## Requirements
- R1: The divide ratio N is `div_val` for values 1 to 255, and 256 for a value of 0. For N of 2 or more, one SCK period lasts N system cycles. For N = 1, SCK toggles every system cycle.
- R2: Within a period, SCK is high for floor(N/2) cycles and low for ceil(N/2) cycles, with a minimum of 1 cycle for each phase.
- R3: Bit 0 of `sig_mode` is the polarity. While the block is not running, `sck` takes the bit-0 value seen at the previous clock edge (0 means idle low, 1 means idle high).
- R4: The edge that accepts a request is the edge where `run` and `en` are high and the block is idle. The first SCK edge follows that edge after exactly the length of the idle-level phase (R2).
- R5: Bit 1 of `sig_mode` is the output phase. When it is 0, `drive_stb` pulses on trailing edges (back to idle). When it is 1, `drive_stb` pulses on leading edges (away from idle). The pulse is high in the cycle in which `sck` shows the new level.
- R6: Bit 2 of `sig_mode` is the input phase. When it is 0, `sample_stb` pulses on leading edges. When it is 1, `sample_stb` pulses on trailing edges. This bit is independent of bit 1.
- R7: `clk_count` clears to 0 when a request is accepted. It rises by one in the cycle of each trailing edge.
- R8: With `run` low, the block stops at the first phase boundary where SCK sits at its idle level. No further leading edge is made, and `running` falls at that boundary.
- R9: `en` low forces `running` low and `sck` to the bit-0 value at the next edge, and gives no strobes.
- R10: Changes to `div_val` and `sig_mode` while running have no effect until the block is idle again.
- R11: No strobe is given while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low aborts at once |
| div_val | input | DIV_W | Divider value, 0 meaning 2**DIV_W |
| sig_mode | input | 3 | {input phase, output phase, polarity} |
| run | input | 1 | Clock request from the transfer engine |
| sck | output | 1 | Serial clock level |
| drive_stb | output | 1 | Drive-edge strobe |
| sample_stb | output | 1 | Sample-edge strobe |
| running | output | 1 | Generator is producing clocks |
| clk_count | output | CNT_W | Clocks completed since the request was accepted |

## Verification
The hardest situation to reach is a stop request or a field change that lands in the middle of a run. The outcome then depends on whether SCK is at its idle or its active level when the next phase boundary arrives. The stimulus drops `run` in the cycle directly after a trailing edge, so the stop happens at the boundary that would otherwise make a leading edge. In randomised cases it also overwrites both fields after the first completed clock and keeps measuring every phase against the original values. Divider values 1, 0 (256) and odd ratios are forced as directed cases, because random picks rarely land on them.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;
  typedef struct packed {
    logic in_cpha;
    logic out_cpha;
    logic cpol;
  } sig_mode_t;
endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold
  import sck_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [DIV_W-1:0] div_in,
  input  sig_mode_t        mode_in,
  output logic [DIV_W-1:0] div_out,
  output sig_mode_t        mode_out
);
  logic [DIV_W-1:0] div_q;
  sig_mode_t        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= '0;
    end else if (capture) begin
      div_q  <= div_in;
      mode_q <= mode_in;
    end
  end

  // while idle the live inputs are used, during a run the held copy
  assign div_out  = capture ? div_in : div_q;
  assign mode_out = capture ? mode_in : mode_q;
endmodule

// File: rtl/sck_half_timer.sv
module sck_half_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/sck_strobe_gen.sv
module sck_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  input  logic leading,
  input  logic out_cpha,
  input  logic in_cpha,
  output logic drive_stb,
  output logic sample_stb
);
  logic drive_d, sample_d;

  always_comb begin
    drive_d  = fire && (leading ? out_cpha : !out_cpha);
    sample_d = fire && (leading ? !in_cpha : in_cpha);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (clear) begin
      drive_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      drive_stb  <= drive_d;
      sample_stb <= sample_d;
    end
  end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import sck_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [2:0]       sig_mode,
  input  logic             run,
  output logic             sck,
  output logic             drive_stb,
  output logic             sample_stb,
  output logic             running,
  output logic [CNT_W-1:0] clk_count
);
  localparam int LEN_W = DIV_W + 1;
  localparam logic [LEN_W-1:0] FULL_RATIO = LEN_W'(1) << DIV_W;

  function automatic logic [LEN_W-1:0] phase_len(input logic [DIV_W-1:0] d,
                                                 input logic lvl);
    logic [LEN_W-1:0] n, hi, lo;
    n  = (d == '0) ? FULL_RATIO : {1'b0, d};
    hi = n >> 1;
    lo = n - hi;
    if (hi == '0) hi = LEN_W'(1);
    return lvl ? hi : lo;
  endfunction

  logic [DIV_W-1:0] cur_div;
  sig_mode_t        cur_mode;
  logic             expire, at_boundary, at_idle_lvl, stop_now, toggle, start;
  logic             tmr_load;
  logic [LEN_W-1:0] next_len;
  logic [DIV_W-1:0] tmr_val;

  sck_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (!running),
    .div_in   (div_val),
    .mode_in  (sig_mode_t'(sig_mode)),
    .div_out  (cur_div),
    .mode_out (cur_mode)
  );

  always_comb begin
    at_boundary = running && expire;
    at_idle_lvl = (sck == cur_mode.cpol);
    stop_now    = at_boundary && at_idle_lvl && !run;
    toggle      = en && at_boundary && !stop_now;
    start       = en && run && !running;
    tmr_load    = start || toggle;
    next_len    = phase_len(cur_div, start ? cur_mode.cpol : !sck);
    tmr_val     = DIV_W'(next_len - LEN_W'(1));
  end

  sck_half_timer #(.W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  sck_strobe_gen u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (!en),
    .fire       (toggle),
    .leading    (at_idle_lvl),
    .out_cpha   (cur_mode.out_cpha),
    .in_cpha    (cur_mode.in_cpha),
    .drive_stb  (drive_stb),
    .sample_stb (sample_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      sck       <= 1'b0;
      clk_count <= '0;
    end else if (!en) begin
      running <= 1'b0;
      sck     <= sig_mode[0];
    end else if (!running) begin
      sck <= sig_mode[0];
      if (run) begin
        running   <= 1'b1;
        clk_count <= '0;
      end
    end else if (stop_now) begin
      running <= 1'b0;
    end else if (toggle) begin
      sck <= !sck;
      if (!at_idle_lvl) clk_count <= clk_count + 1'b1;
    end
  end
endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [DIV_W-1:0] div_val,
  input logic [2:0]       sig_mode,
  input logic             run,
  input logic             sck,
  input logic             drive_stb,
  input logic             sample_stb,
  input logic             running,
  input logic [CNT_W-1:0] clk_count
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(running) && !running) |-> (sck == $past(sig_mode[0]))); // R3

  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(run && en)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |->
      (clk_count == $past(clk_count) || clk_count == $past(clk_count) + 1'b1)); // R7

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!running && !drive_stb && !sample_stb)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(running) |-> (!drive_stb && !sample_stb)); // R11

  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_stb || sample_stb) |-> (sck != $past(sck))); // R5
endmodule

bind spi_sck_gen spi_sck_gen_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .div_val    (div_val),
  .sig_mode   (sig_mode),
  .run        (run),
  .sck        (sck),
  .drive_stb  (drive_stb),
  .sample_stb (sample_stb),
  .running    (running),
  .clk_count  (clk_count)
);

// File: tb/test_spi_sck_gen.sv
`timescale 1ns/1ps
module test_spi_sck_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div_val = 8'd0;
  logic [2:0]  sig_mode = 3'd0;
  logic        run = 1'b0;
  logic        sck, drive_stb, sample_stb, running;
  logic [15:0] clk_count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_sck_gen i_spi_sck_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val), .sig_mode(sig_mode),
    .run(run), .sck(sck), .drive_stb(drive_stb), .sample_stb(sample_stb),
    .running(running), .clk_count(clk_count)
  );

  // expected phase length from R1/R2
  function automatic int plen(input int d, input bit lvl);
    int n, hi, lo;
    n  = (d == 0) ? 256 : d;
    hi = n / 2;
    lo = n - hi;
    if (hi == 0) hi = 1;
    return lvl ? hi : lo;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int d, input bit [2:0] m, input int nclk, input bit disturb);
    bit cpol, lvl, leading, first;
    int j, clocks;
    string req;
    cpol = m[0];
    @(negedge clk);
    div_val = 8'(d); sig_mode = m; run = 1'b0;
    repeat (2) @(negedge clk);
    chk(sck == cpol, "R3 idle level", int'(sck), int'(cpol));
    chk(!drive_stb && !sample_stb, "R11 idle strobes", int'({drive_stb, sample_stb}), 0);
    run = 1'b1;
    j = 0; clocks = 0; lvl = cpol; first = 1'b1;
    forever begin
      @(negedge clk);
      j++;
      if (disturb && clocks == 1) begin
        div_val = 8'($urandom); sig_mode = 3'($urandom);
      end
      if (sck != lvl) begin
        leading = (lvl == cpol);
        req = disturb ? "R10 phase" : (first ? "R4 first edge" : "R1,R2 phase");
        chk(j == (first ? plen(d, lvl) + 1 : plen(d, lvl)), req, j,
            first ? plen(d, lvl) + 1 : plen(d, lvl));
        chk(drive_stb == (leading ? m[1] : !m[1]), "R5 drive strobe",
            int'(drive_stb), int'(leading ? m[1] : !m[1]));
        chk(sample_stb == (leading ? !m[2] : m[2]), "R6 sample strobe",
            int'(sample_stb), int'(leading ? !m[2] : m[2]));
        if (!leading) clocks++;
        chk(clk_count == 16'(clocks), "R7 clock count", int'(clk_count), clocks);
        lvl = sck; j = 0; first = 1'b0;
        if (!leading && clocks == nclk) break;
      end else begin
        chk(!drive_stb && !sample_stb, "R5,R6 no strobe off edge",
            int'({drive_stb, sample_stb}), 0);
      end
      if (j > 600) begin
        chk(1'b0, "R1 edge timeout", j, 600);
        break;
      end
    end
    div_val = 8'(d); sig_mode = m; run = 1'b0;
    for (int k = 0; k < plen(d, cpol) + 1; k++) begin
      @(negedge clk);
      chk(sck == cpol, "R8 stays idle after stop", int'(sck), int'(cpol));
    end
    chk(!running, "R8 stopped", int'(running), 0);
    chk(clk_count == 16'(nclk), "R8 final count", int'(clk_count), nclk);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    chk(!running && sck == 1'b0, "R3 reset state", int'({running, sck}), 0);
    chk(clk_count == 0 && !drive_stb && !sample_stb, "R11 reset quiet", int'(clk_count), 0);

    // idle follows polarity bit
    sig_mode = 3'b001;
    @(negedge clk);
    chk(sck == 1'b1, "R3 idle high", int'(sck), 1);
    sig_mode = 3'b000;
    @(negedge clk);
    chk(sck == 1'b0, "R3 idle low", int'(sck), 0);

    // directed corners: fastest divider in all modes, divide by 256, odd, even
    for (int m = 0; m < 8; m++) run_case(1, 3'(m), 3, 1'b0);
    run_case(0, 3'b000, 2, 1'b0);
    run_case(0, 3'b111, 2, 1'b0);
    run_case(7, 3'b110, 3, 1'b0);
    run_case(2, 3'b001, 4, 1'b0);
    run_case(5, 3'b100, 3, 1'b1);

    // constrained random
    for (int k = 0; k < 14; k++)
      run_case(int'($urandom_range(0, 40)), 3'($urandom), int'($urandom_range(1, 4)), k[0]);

    // abort with en low
    @(negedge clk);
    div_val = 8'd4; sig_mode = 3'b001; run = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!running, "R9 abort running", int'(running), 0);
    chk(sck == 1'b1, "R9 abort level", int'(sck), 1);
    chk(!drive_stb && !sample_stb, "R9 abort strobes", int'({drive_stb, sample_stb}), 0);
    run = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule